// File: doc/BRIEF.md
# Stream Byte-to-Word Packer

This block sits at the tail of an encoder pipeline. Upstream logic produces stream bytes at an uneven rate, from zero to four bytes per clock. The block appends them in arrival order into 32-byte output words. The first byte of the stream goes into the lowest byte lane of a word. A word is presented on a valid strobe once the sequence is known to continue past it, or once the sequence ends. There is no backpressure on the output side.

An end-of-sequence marker closes the current sequence. A partly filled word is padded with zero bytes and sent out with a last flag. A word that was filled exactly takes the last flag itself, so no extra padding word follows it. A sequence that closes without carrying any data produces one all-zero word flagged last. A busy output frames the whole sequence, and the output strobe is never raised while busy is low.

Top module: `stream_word_packer`

## Requirements
- R1: Stream byte n of a sequence appears in output word n/32, in bits [8*(n%32)+7 : 8*(n%32)]. Within a cycle, input byte j is taken from `in_bytes[8j+7:8j]` and precedes byte j+1. Only the lowest `in_cnt` input bytes are used.
- R2: If the accepted bytes push the stored count beyond 32, the 32 oldest bytes go out the next cycle with `out_vld` high and `out_last` low. The surplus bytes begin the next word at lane 0.
- R3: A word that is filled exactly is held back. It goes out, without last, the cycle after a further byte is accepted. If the end marker arrives first, it goes out with last the cycle after the marker, and no padding word follows.
- R4: When the end marker arrives and the stored count (including that cycle's bytes) is between 1 and 31, the next cycle carries that word with `out_last` high and zero bytes in every unused upper lane.
- R5: If the end marker comes with bytes that overflow a word, the full word goes out the next cycle without last. The cycle after that carries the zero-padded remainder with last. Inputs are ignored in that second cycle.
- R6: An end marker with no byte written in the sequence produces exactly one all-zero word with `out_last` high, on the next cycle.
- R7: `busy` rises the cycle after the first accepted byte or end marker. It stays high through the last word and falls on the cycle after it. `out_vld` is never high while `busy` is low.
- R8: The asynchronous active-low reset clears `busy`, `out_vld`, `out_last` and the stored byte count, so the next sequence starts at lane 0. Its release is synchronised to the clock over two cycles.
- R9: A cycle with `in_cnt` = 0 and no end marker adds no byte and emits no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_cnt | input | 3 | Number of valid bytes this cycle, 0 to 4 |
| in_bytes | input | 32 | Input bytes, earliest in bits [7:0] |
| in_eos | input | 1 | End of sequence marker for this cycle |
| busy | output | 1 | A sequence is in progress |
| out_vld | output | 1 | `out_data` holds a stream word |
| out_last | output | 1 | Final word of the sequence (with `out_vld`) |
| out_data | output | 256 | 32 stream bytes, first byte in bits [7:0] |

## Verification
The bench builds the block with its default parameters: four bytes in per cycle and 32-byte words. These are small enough to sweep every sequence length from 0 to 70 bytes under four byte-count patterns. Those patterns include idle gaps and odd counts that straddle word edges. Each length is closed once with the end marker on the final bytes and once with it in a separate cycle. Together these reach every end-of-sequence case: empty, partial, exactly full and overflowing.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

  // what the word store does with its byte buffer this cycle
  typedef enum logic [1:0] {
    BUF_LO  = 2'd0,   // take the merged low word (still filling)
    BUF_HI  = 2'd1,   // start a fresh word from the overflow bytes
    BUF_CLR = 2'd2    // sequence closed, empty the buffer
  } buf_sel_e;

  // what the output register presents next cycle
  typedef enum logic [1:0] {
    EMIT_NONE = 2'd0,
    EMIT_WORD = 2'd1,
    EMIT_LAST = 2'd2
  } emit_e;

endpackage

// File: rtl/pkr_lane_merge.sv
module pkr_lane_merge #(
  parameter int IN_BYTES   = 4,
  parameter int WORD_BYTES = 32,
  parameter int FILL_W     = 6,
  parameter int SUM_W      = 6,
  parameter int CNT_W      = 3
) (
  input  logic [8*WORD_BYTES-1:0] buf_data,
  input  logic [FILL_W-1:0]       fill,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [8*IN_BYTES-1:0]   in_bytes,
  output logic [8*WORD_BYTES-1:0] lo_word,
  output logic [8*IN_BYTES-1:0]   hi_bytes
);

  localparam int LANES = WORD_BYTES + IN_BYTES;

  // each lane of the extended word selects either a stored byte or the
  // incoming byte whose stream position lands on it
  for (genvar K = 0; K < LANES; K++) begin : g_lane
    logic [SUM_W-1:0] rel;
    logic [7:0]       lane_v;

    always_comb begin
      lane_v = '0;
      rel    = SUM_W'(K) - SUM_W'(fill);
      if (SUM_W'(K) >= SUM_W'(fill)) begin
        for (int j = 0; j < IN_BYTES; j++) begin
          if (rel == SUM_W'(j) && CNT_W'(j) < cnt) begin
            lane_v = in_bytes[8*j +: 8];
          end
        end
      end
    end

    if (K < WORD_BYTES) begin : g_low
      assign lo_word[8*K +: 8] = (SUM_W'(K) < SUM_W'(fill)) ? buf_data[8*K +: 8] : lane_v;
    end else begin : g_high
      assign hi_bytes[8*(K-WORD_BYTES) +: 8] = lane_v;
    end
  end

endmodule

// File: rtl/pkr_seq_ctrl.sv
module pkr_seq_ctrl
  import pkr_pkg::*;
#(
  parameter int IN_BYTES   = 4,
  parameter int WORD_BYTES = 32,
  parameter int FILL_W     = 6,
  parameter int SUM_W      = 6,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic              in_eos,
  input  logic              last_seen,
  output logic [CNT_W-1:0]  cnt_eff,
  output logic [FILL_W-1:0] fill_q,
  output logic              flush_q,
  output logic              busy_q,
  output logic              buf_en,
  output buf_sel_e          buf_sel,
  output emit_e             emit
);

  logic              eos_eff;
  logic [SUM_W-1:0]  sum;
  logic [FILL_W-1:0] fill_n;
  logic              flush_n;
  logic              busy_n;

  // next-state logic
  always_comb begin
    cnt_eff = flush_q ? '0 : in_cnt;
    eos_eff = in_eos & ~flush_q;
    sum     = SUM_W'(fill_q) + SUM_W'(cnt_eff);
    buf_en  = flush_q | (cnt_eff != '0) | eos_eff;
    flush_n = 1'b0;
    if (flush_q) begin
      emit    = EMIT_LAST;
      buf_sel = BUF_CLR;
      fill_n  = '0;
    end else if (sum > SUM_W'(WORD_BYTES)) begin
      emit    = EMIT_WORD;
      buf_sel = BUF_HI;
      fill_n  = FILL_W'(sum - SUM_W'(WORD_BYTES));
      flush_n = eos_eff;
    end else if (eos_eff) begin
      emit    = EMIT_LAST;
      buf_sel = BUF_CLR;
      fill_n  = '0;
    end else begin
      emit    = EMIT_NONE;
      buf_sel = BUF_LO;
      fill_n  = FILL_W'(sum);
    end

    if (last_seen) begin
      busy_n = 1'b0;
    end else if ((cnt_eff != '0) || eos_eff) begin
      busy_n = 1'b1;
    end else begin
      busy_n = busy_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      flush_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (buf_en) begin
        fill_q  <= fill_n;
        flush_q <= flush_n;
      end
      busy_q <= busy_n;
    end
  end

  // R5: a pending flush only ever holds a short overflow remainder
  a_r5_flush_fill_range: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (fill_q != '0 && fill_q <= FILL_W'(IN_BYTES)));

  // R7: the sequence ends the cycle after its last word is shown
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    last_seen |=> !busy_q);

endmodule

// File: rtl/pkr_word_store.sv
module pkr_word_store
  import pkr_pkg::*;
#(
  parameter int IN_BYTES   = 4,
  parameter int WORD_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8*WORD_BYTES-1:0] lo_word,
  input  logic [8*IN_BYTES-1:0]   hi_bytes,
  input  logic                    buf_en,
  input  buf_sel_e                buf_sel,
  input  emit_e                   emit,
  output logic [8*WORD_BYTES-1:0] buf_q,
  output logic                    out_vld_q,
  output logic                    out_last_q,
  output logic [8*WORD_BYTES-1:0] out_data_q
);

  logic [8*WORD_BYTES-1:0] buf_n;
  logic                    out_en;

  always_comb begin
    buf_n = '0;
    case (buf_sel)
      BUF_LO:  buf_n = lo_word;
      BUF_HI:  buf_n[8*IN_BYTES-1:0] = hi_bytes;
      default: buf_n = '0;
    endcase
    out_en = (emit != EMIT_NONE);
  end

  // the buffer keeps unused lanes at zero, which supplies the padding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      out_vld_q  <= 1'b0;
      out_last_q <= 1'b0;
    end else begin
      if (buf_en) begin
        buf_q <= buf_n;
      end
      out_vld_q  <= out_en;
      out_last_q <= (emit == EMIT_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (out_en) begin
      out_data_q <= lo_word;
    end
  end

  // R3: the last flag never stands without a word
  a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_q |-> out_vld_q);

endmodule

// File: rtl/stream_word_packer.sv
module stream_word_packer
  import pkr_pkg::*;
#(
  parameter int IN_BYTES   = 4,
  parameter int WORD_BYTES = 32,
  localparam int CNT_W     = $clog2(IN_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        in_cnt,
  input  logic [8*IN_BYTES-1:0]   in_bytes,
  input  logic                    in_eos,
  output logic                    busy,
  output logic                    out_vld,
  output logic                    out_last,
  output logic [8*WORD_BYTES-1:0] out_data
);

  localparam int FILL_W = $clog2(WORD_BYTES + 1);
  localparam int SUM_W  = $clog2(WORD_BYTES + IN_BYTES + 1);

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [CNT_W-1:0]        cnt_eff;
  logic [FILL_W-1:0]       fill_q;
  logic                    flush_q;
  logic                    buf_en;
  buf_sel_e                buf_sel;
  emit_e                   emit;
  logic [8*WORD_BYTES-1:0] buf_q;
  logic [8*WORD_BYTES-1:0] lo_word;
  logic [8*IN_BYTES-1:0]   hi_bytes;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  pkr_lane_merge #(
    .IN_BYTES(IN_BYTES), .WORD_BYTES(WORD_BYTES),
    .FILL_W(FILL_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
  ) u_merge (
    .buf_data(buf_q),
    .fill    (fill_q),
    .cnt     (cnt_eff),
    .in_bytes(in_bytes),
    .lo_word (lo_word),
    .hi_bytes(hi_bytes)
  );

  pkr_seq_ctrl #(
    .IN_BYTES(IN_BYTES), .WORD_BYTES(WORD_BYTES),
    .FILL_W(FILL_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_cnt   (in_cnt),
    .in_eos   (in_eos),
    .last_seen(out_vld & out_last),
    .cnt_eff  (cnt_eff),
    .fill_q   (fill_q),
    .flush_q  (flush_q),
    .busy_q   (busy),
    .buf_en   (buf_en),
    .buf_sel  (buf_sel),
    .emit     (emit)
  );

  pkr_word_store #(
    .IN_BYTES(IN_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lo_word   (lo_word),
    .hi_bytes  (hi_bytes),
    .buf_en    (buf_en),
    .buf_sel   (buf_sel),
    .emit      (emit),
    .buf_q     (buf_q),
    .out_vld_q (out_vld),
    .out_last_q(out_last),
    .out_data_q(out_data)
  );

  // R7: no word is shown outside a sequence
  a_r7_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_vld |-> busy);

  // R5: a pending flush turns into the final word on the next cycle
  a_r5_flush_emits_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_q |=> (out_vld && out_last));

  // R6: closing an empty sequence yields one zero word flagged last
  a_r6_empty_zero_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_eos && !flush_q && fill_q == '0 && in_cnt == '0)
      |=> (out_vld && out_last && out_data == '0));

endmodule

// File: tb/sim_stream_word_packer.sv
module sim_stream_word_packer;

  localparam int IB = 4;
  localparam int WB = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   in_cnt;
  logic [31:0]  in_bytes;
  logic         in_eos;
  logic         busy;
  logic         out_vld;
  logic         out_last;
  logic [255:0] out_data;

  always #10 clk = ~clk;

  stream_word_packer u0 (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_bytes(in_bytes),
    .in_eos(in_eos), .busy(busy), .out_vld(out_vld), .out_last(out_last),
    .out_data(out_data)
  );

  int checks = 0;
  int fails = 0;
  int total_words = 0;
  int base_words = 0;
  int cur_seq = 0;
  int cur_len = 0;
  int f_m = 0;
  bit fl_m = 0;
  int pos = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s seq=%0d len=%0d actual=%h expected=%h", tag, cur_seq, cur_len, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_val(input int s, input int i);
    return 8'(s * 29 + i * 11 + 1);
  endfunction

  function automatic logic [255:0] exp_word(input int s, input int w, input int len);
    logic [255:0] v = '0;
    for (int k = 0; k < WB; k++) begin
      if (w * WB + k < len) v[8*k +: 8] = byte_val(s, w * WB + k);
    end
    return v;
  endfunction

  function automatic int n_words(input int len);
    return (len == 0) ? 1 : (len + WB - 1) / WB;
  endfunction

  // word content monitor: R1 lane order, R4/R6 padding, R3 last placement
  always @(negedge clk) begin
    if (rst_n && out_vld && !finished) begin
      int w;
      w = total_words - base_words;
      chk(out_data == exp_word(cur_seq, w, cur_len), "R1", out_data,
          exp_word(cur_seq, w, cur_len));
      chk(out_last == (w == n_words(cur_len) - 1), "R3", 256'(out_last),
          256'(w == n_words(cur_len) - 1));
      chk(busy == 1'b1, "R7", 256'(busy), 256'(1));
      total_words++;
    end
  end

  // one input cycle, then check the strobes against the fill model
  task automatic step(input int c, input bit eos);
    int t;
    bit ev, el;
    string tag;
    in_cnt = 3'(c);
    in_eos = eos;
    for (int j = 0; j < IB; j++)
      in_bytes[8*j +: 8] = (j < c) ? byte_val(cur_seq, pos + j) : 8'hA5;
    @(posedge clk);
    @(negedge clk);
    in_cnt = '0;
    in_eos = 1'b0;
    in_bytes = 32'hDEADBEEF;
    t = f_m + c;
    if (fl_m) begin
      ev = 1; el = 1; f_m = 0; fl_m = 0; tag = "R5";
    end else if (t > WB) begin
      ev = 1; el = 0; f_m = t - WB; fl_m = eos; tag = eos ? "R5" : "R2";
    end else if (eos) begin
      ev = 1; el = 1; f_m = 0;
      tag = (t == 0) ? "R6" : ((t == WB) ? "R3" : "R4");
    end else begin
      ev = 0; el = 0; f_m = t;
      tag = (c == 0) ? "R9" : ((t == WB) ? "R3" : "R2");
    end
    pos += c;
    chk(out_vld == ev, tag, 256'(out_vld), 256'(ev));
    chk(out_last == el, tag, 256'(out_last), 256'(el));
    if (c > 0 || eos || ev) chk(busy == 1'b1, "R7", 256'(busy), 256'(1));
  endtask

  function automatic int pattern(input int mode, input int i);
    case (mode)
      0: return 4;
      1: return 3;
      2: return i % 5;
      default: return (i * 3 + 1) % 5;
    endcase
  endfunction

  task automatic run_seq(input int len, input int mode, input bit sep_eos);
    int i = 0;
    cur_seq++;
    cur_len = len;
    base_words = total_words;
    pos = 0; f_m = 0; fl_m = 0;
    while (pos < len) begin
      int c;
      c = pattern(mode, i);
      if (c > len - pos) c = len - pos;
      step(c, !sep_eos && c > 0 && (pos + c == len));
      i++;
    end
    if (sep_eos || len == 0) step(0, 1);
    if (fl_m) step(0, 0);
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && out_vld == 1'b0, "R7", 256'({busy, out_vld}), 256'(0));
    chk(total_words - base_words == n_words(len), "R6",
        256'(total_words - base_words), 256'(n_words(len)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_cnt = '0;
    in_eos = 1'b0;
    in_bytes = '0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet while reset is held
    chk({busy, out_vld, out_last} == 3'b000, "R8", 256'({busy, out_vld, out_last}), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, out_vld, out_last} == 3'b000, "R8", 256'({busy, out_vld, out_last}), 256'(0));

    // near-exhaustive sweep over lengths, count patterns and end styles
    for (int len = 0; len <= 70; len++)
      for (int mode = 0; mode < 4; mode++)
        for (int se = 0; se < 2; se++)
          run_seq(len, mode, se[0]);

    // R8: reset in the middle of a sequence discards the stored bytes
    cur_seq++;
    cur_len = 0;
    pos = 0; f_m = 0; fl_m = 0;
    base_words = total_words;
    repeat (3) step(4, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy, out_vld, out_last} == 3'b000, "R8", 256'({busy, out_vld, out_last}), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(total_words == base_words, "R8", 256'(total_words - base_words), 256'(0));
    run_seq(5, 0, 0);
    run_seq(40, 3, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule